// File: doc/BRIEF.md
# Single-Operand Arithmetic, Rotate and Shift Unit

This block is the one-operand half of a processor execute stage. A request carries a data word, an operation code, a byte/word select and the current carry flag. One clock later the unit presents the result and the four condition flags: negative (N), zero (Z), overflow (V) and carry (C). It raises a valid strobe with them. The surrounding pipeline handles operand fetch and write-back.

The operations are clear, complement, increment, decrement, negate, add-carry, subtract-carry, test, rotate right, rotate left, arithmetic shift right, arithmetic shift left and byte swap. Each one has its own rule for V and C. In byte mode only the low half of the word is processed and the sign sits at bit 7. A code outside the supported set returns the operand unchanged, keeps the previous flags and flags the request as illegal.

Top module: `sop_alu`

## Requirements
- R1: A request accepted at a clock edge with `in_valid` high appears on the outputs after that edge, with `out_valid` high for one cycle. While no request arrives, `out_valid` and `out_illegal` are low and the result and flags hold their last values. Reset clears the result, the flags and the strobes.
- R2: Clear (code 0) returns 0 with N=0, Z=1, V=0, C=0.
- R3: Complement (code 1) inverts every bit of the active width, clears V and sets C.
- R4: Increment (code 2) sets V only when the operand is the largest positive value of the active width (0x7FFF, or 0x7F in byte mode). Decrement (code 3) sets V only when the operand is the most negative value (0x8000 or 0x80). Both copy the incoming carry to C.
- R5: Negate (code 4) returns the two's complement. V is set when the result is the most negative value, and C is set when the result is non-zero.
- R6: Add-carry (code 5) adds the incoming carry. V is set when the operand is the largest positive value and the carry is 1, and C is set when the operand is all ones and the carry is 1. Subtract-carry (code 6) subtracts the incoming carry. V is set when the operand is the most negative value and the carry is 1, and C is set when the operand is 0 and the carry is 1.
- R7: Test (code 7) returns the operand, sets N and Z from it and clears V and C.
- R8: Rotate right (code 8) moves the incoming carry into the top bit of the active width and bit 0 into C. Rotate left (code 9) moves the incoming carry into bit 0 and the old top bit into C.
- R9: Arithmetic shift right (code 10) keeps the sign bit and moves bit 0 into C. Arithmetic shift left (code 11) shifts a zero into bit 0 and moves the old top bit into C.
- R10: For codes 8 to 11, V equals the new N xor the new C.
- R11: Swap (code 12) exchanges the two bytes of the full word whatever the byte select says. N is bit 7 of the result and Z tests the result's low byte. V and C are cleared.
- R12: In byte mode (`in_byte`=1) the operand's upper byte is ignored, N is result bit 7, Z tests the low byte and the result's upper byte is zero (except for swap).
- R13: Codes 13 to 15 return the full operand unchanged and keep all four flags at their previous values. They raise `out_illegal` together with `out_valid` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_byte | input | 1 | 1 = byte mode, 0 = word mode |
| in_carry | input | 1 | Incoming carry flag |
| in_operand | input | 16 | Operand |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 16 | Result |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |
| out_illegal | output | 1 | Unsupported code strobe |

## Verification
The hardest case to observe is an illegal code. It keeps the flags from before, so the outputs only show something if the previous request left a distinctive, non-reset flag pattern. The bench therefore sends an arithmetic shift left that produces N=1, V=1, C=0, and immediately follows it with an illegal code that carries a carry input of 1. It then checks that the flags survive and that the illegal strobe lasts exactly one cycle. The boundary operands for each overflow and carry rule, in both byte and word mode, are driven one at a time with hand-derived expected values.

// File: rtl/sop_alu_pkg.sv
package sop_alu_pkg;

    typedef enum logic [3:0] {
        OP_CLR  = 4'd0,
        OP_COM  = 4'd1,
        OP_INC  = 4'd2,
        OP_DEC  = 4'd3,
        OP_NEG  = 4'd4,
        OP_ADC  = 4'd5,
        OP_SBC  = 4'd6,
        OP_TST  = 4'd7,
        OP_ROR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ASR  = 4'd10,
        OP_ASL  = 4'd11,
        OP_SWAP = 4'd12
    } sop_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } sop_flags_t;

    function automatic logic op_is_legal(input logic [3:0] op);
        return op <= OP_SWAP;
    endfunction

    function automatic logic op_uses_shifter(input logic [3:0] op);
        return (op >= OP_ROR) && (op <= OP_SWAP);
    endfunction

    function automatic logic op_is_rot_shift(input logic [3:0] op);
        return (op >= OP_ROR) && (op <= OP_ASL);
    endfunction

endpackage

// File: rtl/sop_arith_unit.sv
module sop_arith_unit
    import sop_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        op,
    input  logic              byte_mode,
    input  logic              cin,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              v_out
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_MASK  = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] TOP_WORD  = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] TOP_BYTE  = ONE << (HALF_W - 1);

    logic [DATA_W-1:0] mask, min_neg, max_pos, a, cin_w;

    always_comb begin
        mask    = byte_mode ? LOW_MASK : '1;
        min_neg = byte_mode ? TOP_BYTE : TOP_WORD;
        max_pos = mask >> 1;
        a       = operand & mask;
        cin_w   = {{(DATA_W-1){1'b0}}, cin};
    end

    always_comb begin
        res   = '0;
        c_out = 1'b0;
        v_out = 1'b0;
        case (op)
            OP_CLR: begin
                res = '0;
            end
            OP_COM: begin
                res   = ~a & mask;
                c_out = 1'b1;
            end
            OP_INC: begin
                res   = (a + ONE) & mask;
                v_out = (a == max_pos);
                c_out = cin;
            end
            OP_DEC: begin
                res   = (a - ONE) & mask;
                v_out = (a == min_neg);
                c_out = cin;
            end
            OP_NEG: begin
                res   = (~a + ONE) & mask;
                v_out = (res == min_neg);
                c_out = (res != '0);
            end
            OP_ADC: begin
                res   = (a + cin_w) & mask;
                v_out = cin && (a == max_pos);
                c_out = cin && (a == mask);
            end
            OP_SBC: begin
                res   = (a - cin_w) & mask;
                v_out = cin && (a == min_neg);
                c_out = cin && (a == '0);
            end
            OP_TST: begin
                res = a;
            end
            default: begin
                res = a;
            end
        endcase
    end

endmodule

// File: rtl/sop_shift_unit.sv
module sop_shift_unit
    import sop_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        op,
    input  logic              byte_mode,
    input  logic              cin,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              v_from_nc
);
    localparam int HALF_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    localparam logic [DATA_W-1:0] ONE      = {{(DATA_W-1){1'b0}}, 1'b1};
    localparam logic [DATA_W-1:0] TOP_WORD = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] TOP_BYTE = ONE << (HALF_W - 1);

    logic [DATA_W-1:0] mask, top_bit, a, cin_w;
    logic              a_sign;

    always_comb begin
        mask    = byte_mode ? LOW_MASK : '1;
        top_bit = byte_mode ? TOP_BYTE : TOP_WORD;
        a       = operand & mask;
        a_sign  = (a & top_bit) != '0;
        cin_w   = {{(DATA_W-1){1'b0}}, cin};
    end

    always_comb begin
        res       = a;
        c_out     = 1'b0;
        v_from_nc = op_is_rot_shift(op);
        case (op)
            OP_ROR: begin
                res   = (a >> 1) | (cin ? top_bit : '0);
                c_out = a[0];
            end
            OP_ROL: begin
                res   = ((a << 1) | cin_w) & mask;
                c_out = a_sign;
            end
            OP_ASR: begin
                res   = (a >> 1) | (a & top_bit);
                c_out = a[0];
            end
            OP_ASL: begin
                res   = (a << 1) & mask;
                c_out = a_sign;
            end
            OP_SWAP: begin
                res   = {operand[HALF_W-1:0], operand[DATA_W-1:HALF_W]};
                c_out = 1'b0;
            end
            default: begin
                res   = a;
                c_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sop_flag_merge.sv
module sop_flag_merge
    import sop_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [3:0]        op,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] operand,
    input  sop_flags_t        prev_flags,
    input  logic [DATA_W-1:0] arith_res,
    input  logic              arith_c,
    input  logic              arith_v,
    input  logic [DATA_W-1:0] shift_res,
    input  logic              shift_c,
    input  logic              shift_v_nc,
    output logic [DATA_W-1:0] result,
    output sop_flags_t        flags,
    output logic              illegal
);
    localparam int HALF_W = DATA_W / 2;

    logic              legal, use_shift, low_view;
    logic [DATA_W-1:0] sel_res;
    logic              sel_c, sel_n;

    always_comb begin
        legal     = op_is_legal(op);
        use_shift = op_uses_shifter(op);
        low_view  = byte_mode || (op == OP_SWAP);
        sel_res   = use_shift ? shift_res : arith_res;
        sel_c     = use_shift ? shift_c : arith_c;
        sel_n     = low_view ? sel_res[HALF_W-1] : sel_res[DATA_W-1];
    end

    always_comb begin
        illegal = !legal;
        if (legal) begin
            result  = sel_res;
            flags.n = sel_n;
            flags.z = low_view ? (sel_res[HALF_W-1:0] == '0) : (sel_res == '0);
            flags.c = sel_c;
            flags.v = (use_shift && shift_v_nc) ? (sel_n ^ sel_c)
                    : (use_shift ? 1'b0 : arith_v);
        end else begin
            result = operand;
            flags  = prev_flags;
        end
    end

endmodule

// File: rtl/sop_alu.sv
module sop_alu
    import sop_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic              in_byte,
    input  logic              in_carry,
    input  logic [DATA_W-1:0] in_operand,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_n,
    output logic              out_z,
    output logic              out_v,
    output logic              out_c,
    output logic              out_illegal
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] arith_res, shift_res, next_res;
    logic              arith_c, arith_v, shift_c, shift_v_nc, next_ill;
    sop_flags_t        next_flags, r_flags;
    logic [DATA_W-1:0] r_res;
    logic              r_valid, r_ill, r_byte;
    logic [3:0]        r_op;

    sop_arith_unit #(.DATA_W(DATA_W)) u_arith (
        .op(in_op), .byte_mode(in_byte), .cin(in_carry), .operand(in_operand),
        .res(arith_res), .c_out(arith_c), .v_out(arith_v)
    );

    sop_shift_unit #(.DATA_W(DATA_W)) u_shift (
        .op(in_op), .byte_mode(in_byte), .cin(in_carry), .operand(in_operand),
        .res(shift_res), .c_out(shift_c), .v_from_nc(shift_v_nc)
    );

    sop_flag_merge #(.DATA_W(DATA_W)) u_merge (
        .op(in_op), .byte_mode(in_byte), .operand(in_operand),
        .prev_flags(r_flags),
        .arith_res(arith_res), .arith_c(arith_c), .arith_v(arith_v),
        .shift_res(shift_res), .shift_c(shift_c), .shift_v_nc(shift_v_nc),
        .result(next_res), .flags(next_flags), .illegal(next_ill)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            r_valid <= 1'b0;
            r_ill   <= 1'b0;
            r_res   <= '0;
            r_flags <= '0;
            r_op    <= OP_CLR;
            r_byte  <= 1'b0;
        end else begin
            r_valid <= in_valid;
            r_ill   <= in_valid && next_ill;
            if (in_valid) begin
                r_res   <= next_res;
                r_flags <= next_flags;
                r_op    <= in_op;
                r_byte  <= in_byte;
            end
        end
    end

    assign out_valid   = r_valid;
    assign out_result  = r_res;
    assign out_n       = r_flags.n;
    assign out_z       = r_flags.z;
    assign out_v       = r_flags.v;
    assign out_c       = r_flags.c;
    assign out_illegal = r_ill;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("valid strobe missing"); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && $stable(out_result))) else $error("idle changed outputs"); // R1
    AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r_op == OP_CLR) |-> (out_result == '0 && out_z && !out_n && !out_v && !out_c)) else $error("clear flags"); // R2
    AST_COM_CARRY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r_op == OP_COM) |-> (out_c && !out_v)) else $error("complement flags"); // R3
    AST_NEG_CARRY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r_op == OP_NEG) |-> (out_c == (out_result != '0))) else $error("negate carry"); // R5
    AST_TST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r_op == OP_TST) |-> (!out_v && !out_c)) else $error("test flags"); // R7
    AST_SHIFT_V: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r_op >= OP_ROR && r_op <= OP_ASL) |-> (out_v == (out_n ^ out_c))) else $error("shift overflow rule"); // R10
    AST_SWAP_VC: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r_op == OP_SWAP) |-> (!out_v && !out_c)) else $error("swap flags"); // R11
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
        (out_valid && r_byte && r_op < OP_SWAP) |-> (out_result[DATA_W-1:HALF_W] == '0)) else $error("byte upper nonzero"); // R12
    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> ($stable({out_n, out_z, out_v, out_c}) && out_valid)) else $error("illegal changed flags"); // R13

endmodule

// File: tb/sop_alu_tb.sv
module sop_alu_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_byte, in_carry;
    logic [3:0]  in_op;
    logic [15:0] in_operand;
    logic        out_valid, out_n, out_z, out_v, out_c, out_illegal;
    logic [15:0] out_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sop_alu u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_byte(in_byte), .in_carry(in_carry), .in_operand(in_operand),
        .out_valid(out_valid), .out_result(out_result), .out_n(out_n),
        .out_z(out_z), .out_v(out_v), .out_c(out_c), .out_illegal(out_illegal)
    );

    task automatic check(input string tag, input logic [21:0] act, input logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual valid/ill/res/nzvc=%h expected %h", tag, act, exp);
        end
    endtask

    // Issue one request, then sample after the registering edge.
    task automatic run(input string tag, input logic [3:0] op, input logic bm,
                       input logic ci, input logic [15:0] opnd,
                       input logic [15:0] er, input logic [3:0] enzvc, input logic eill);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_byte = bm; in_carry = ci; in_operand = opnd;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, {out_valid, out_illegal, out_result, out_n, out_z, out_v, out_c},
                   {1'b1, eill, er, enzvc});
    endtask

    task automatic t_reset();
        check("R1 reset", {out_valid, out_illegal, out_result, out_n, out_z, out_v, out_c}, 22'd0);
    endtask

    task automatic t_clear_complement();
        run("R2 clr", 4'd0, 0, 1, 16'h1234, 16'h0000, 4'b0100, 0);
        run("R3 com word", 4'd1, 0, 0, 16'h00FF, 16'hFF00, 4'b1001, 0);
        run("R3 R12 com byte", 4'd1, 1, 0, 16'h12AB, 16'h0054, 4'b0001, 0);
    endtask

    task automatic t_inc_dec();
        run("R4 inc maxpos", 4'd2, 0, 1, 16'h7FFF, 16'h8000, 4'b1011, 0);
        run("R4 R12 inc byte", 4'd2, 1, 0, 16'h007F, 16'h0080, 4'b1010, 0);
        run("R4 inc wrap", 4'd2, 0, 0, 16'hFFFF, 16'h0000, 4'b0100, 0);
        run("R4 dec minneg", 4'd3, 0, 0, 16'h8000, 16'h7FFF, 4'b0010, 0);
        run("R4 R12 dec byte", 4'd3, 1, 1, 16'h3480, 16'h007F, 4'b0011, 0);
    endtask

    task automatic t_negate();
        run("R5 neg minneg", 4'd4, 0, 0, 16'h8000, 16'h8000, 4'b1011, 0);
        run("R5 neg zero", 4'd4, 0, 1, 16'h0000, 16'h0000, 4'b0100, 0);
        run("R5 R12 neg byte", 4'd4, 1, 0, 16'hFF01, 16'h00FF, 4'b1001, 0);
    endtask

    task automatic t_carry_ops();
        run("R6 adc wrap", 4'd5, 0, 1, 16'hFFFF, 16'h0000, 4'b0101, 0);
        run("R6 adc ovf", 4'd5, 0, 1, 16'h7FFF, 16'h8000, 4'b1010, 0);
        run("R6 adc nocarry", 4'd5, 0, 0, 16'hFFFF, 16'hFFFF, 4'b1000, 0);
        run("R6 R12 adc byte", 4'd5, 1, 1, 16'h00FF, 16'h0000, 4'b0101, 0);
        run("R6 sbc borrow", 4'd6, 0, 1, 16'h0000, 16'hFFFF, 4'b1001, 0);
        run("R6 sbc ovf", 4'd6, 0, 1, 16'h8000, 16'h7FFF, 4'b0010, 0);
    endtask

    task automatic t_test();
        run("R7 tst", 4'd7, 0, 1, 16'h8001, 16'h8001, 4'b1000, 0);
        run("R7 R12 tst byte", 4'd7, 1, 1, 16'hAB00, 16'h0000, 4'b0100, 0);
    endtask

    task automatic t_rotates();
        run("R8 R10 ror word", 4'd8, 0, 1, 16'h0001, 16'h8000, 4'b1001, 0);
        run("R8 R10 ror byte", 4'd8, 1, 0, 16'hFF03, 16'h0001, 4'b0011, 0);
        run("R8 R10 rol word", 4'd9, 0, 0, 16'h8000, 16'h0000, 4'b0111, 0);
        run("R8 R10 rol byte", 4'd9, 1, 1, 16'h0040, 16'h0081, 4'b1010, 0);
    endtask

    task automatic t_shifts();
        run("R9 R10 asr word", 4'd10, 0, 0, 16'h8003, 16'hC001, 4'b1001, 0);
        run("R9 R10 asr byte", 4'd10, 1, 0, 16'h0081, 16'h00C0, 4'b1001, 0);
        run("R9 R10 asl byte", 4'd11, 1, 0, 16'h00C0, 16'h0080, 4'b1001, 0);
        run("R9 R10 asl word", 4'd11, 0, 1, 16'h4000, 16'h8000, 4'b1010, 0);
    endtask

    task automatic t_swap();
        run("R11 swap neg", 4'd12, 0, 1, 16'h80FF, 16'hFF80, 4'b1000, 0);
        run("R11 swap zero low", 4'd12, 0, 0, 16'h00AB, 16'hAB00, 4'b0100, 0);
        run("R11 R12 swap byte mode", 4'd12, 1, 1, 16'h1200, 16'h0012, 4'b0000, 0);
    endtask

    task automatic t_illegal();
        run("R13 setup", 4'd11, 0, 0, 16'h4000, 16'h8000, 4'b1010, 0);
        run("R13 illegal", 4'd13, 0, 1, 16'h5A5A, 16'h5A5A, 4'b1010, 1);
        @(negedge clk);
        check("R13 R1 strobe drop", {out_valid, out_illegal, out_result, out_n, out_z, out_v, out_c},
              {1'b0, 1'b0, 16'h5A5A, 4'b1010});
        run("R13 illegal 15 byte", 4'd15, 1, 0, 16'hBEEF, 16'hBEEF, 4'b1010, 1);
    endtask

    task automatic t_idle();
        run("R1 before idle", 4'd2, 0, 0, 16'h0010, 16'h0011, 4'b0000, 0);
        @(negedge clk);
        in_op = 4'd0; in_operand = 16'hFFFF;
        @(negedge clk);
        check("R1 idle hold", {out_valid, out_illegal, out_result, out_n, out_z, out_v, out_c},
              {1'b0, 1'b0, 16'h0011, 4'b0000});
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_op = 4'd0; in_byte = 1'b0;
        in_carry = 1'b0; in_operand = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clear_complement();
        t_inc_dec();
        t_negate();
        t_carry_ops();
        t_test();
        t_rotates();
        t_shifts();
        t_swap();
        t_illegal();
        t_idle();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule